// File: doc/BRIEF.md
# ECC Error Classifier and Reporter

This block sits next to the internal RAMs of a processor core: the register file, the instruction cache tag array, the instruction cache data array and the translation buffer. Each cycle it receives a severity code from each RAM's ECC checker. For the translation buffer it also receives a flag that marks a software-initiated read. From these it decides the action for each error. It can request a transparent correction, ask for the failing cache line to be invalidated and refetched, raise an ECC exception, or set a sticky entry-error flag that software reads.

In parallel it drives a registered 30-bit event bus with a valid strobe, so that outside logic can monitor every detected error. The bus reports errors whether or not checking or the exception path is enabled. A separate bit flags an exception-class error that occurs while the core is already in its exception handler. The ECC decoders, the refill engine and the exception vectoring are external and are reached only through request and acknowledge ports.

Severity code on every `*_sev_i` input: 0 = no error, 1 = single-bit, 2 = double-bit, 3 = triple-bit or worse. All outputs are registered and respond one clock after the inputs are sampled.

Top module: `ecc_fault_router`

## Requirements
- R1: Event bus bit positions: 0 handler-mode error, 1 register file recoverable, 2 register file unrecoverable, 3 cache tag recoverable, 4 cache data recoverable, 19 translation buffer recoverable, 20 translation buffer unrecoverable, 21 translation buffer software read. Every other bit from 0 to 29 is always 0.
- R2: A register file severity of 1 sets bus bit 1 and pulses `rf_fix_o` for one cycle.
- R3: A register file severity of 2 or 3 sets bus bit 2 and is an exception condition.
- R4: Any nonzero cache tag or cache data severity sets bus bit 3 or bit 4 respectively, and requests a line refetch. It never pulses `rf_fix_o`.
- R5: A refetch request stays high with a stable index until `refetch_ack_i` is seen. A cache error that arrives while a request is pending and not acknowledged is not loaded. A cache error in the cycle of the acknowledge loads a new request with the new index.
- R6: On a hardware read of the translation buffer (`tlb_sw_i`=0), severity 1 sets bit 19. Severity 2 or 3 sets bit 20 and is an exception condition.
- R7: On a software read (`tlb_sw_i`=1), any nonzero severity sets bit 21 and sets `tlb_ee_o`. It is never an exception condition.
- R8: `tlb_ee_o` stays set across error-free cycles. It clears on `tlb_ee_clr_i` or `tlb_inval_i`. A new software-read error in the same cycle wins over the clear.
- R9: `exc_req_o` pulses one cycle after an exception condition, and only when both `ecc_en_i` and `ecc_exc_en_i` are 1.
- R10: Event bus bits are produced regardless of `ecc_en_i` and `ecc_exc_en_i`.
- R11: Bit 0 is set together with the specific bit when an exception condition occurs while `handler_mode_i` is 1.
- R12: Errors from several RAMs in one cycle are ORed onto the bus. `evt_valid_o` is high exactly when some bus bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ecc_en_i | input | 1 | ECC checking enable |
| ecc_exc_en_i | input | 1 | ECC exception enable |
| handler_mode_i | input | 1 | Core is in exception handler |
| rf_sev_i | input | 2 | Register file check severity |
| ic_tag_sev_i | input | 2 | Cache tag check severity |
| ic_dat_sev_i | input | 2 | Cache data check severity |
| ic_idx_i | input | IDX_W | Index of the cache line being read |
| tlb_sev_i | input | 2 | Translation buffer check severity |
| tlb_sw_i | input | 1 | Translation buffer read was issued by software |
| tlb_ee_clr_i | input | 1 | Software write clearing the entry-error flag |
| tlb_inval_i | input | 1 | Translation buffer entry invalidate |
| refetch_ack_i | input | 1 | Refill engine accepts the refetch request |
| rf_fix_o | output | 1 | Register file correction request pulse |
| exc_req_o | output | 1 | ECC exception request pulse |
| refetch_req_o | output | 1 | Line invalidate-and-refetch request |
| refetch_idx_o | output | IDX_W | Index of the line to refetch |
| tlb_ee_o | output | 1 | Sticky translation buffer entry-error flag |
| evt_data_o | output | 30 | Registered event bus |
| evt_valid_o | output | 1 | Event bus valid strobe |

## Verification
Two functions can fall in the same cycle. The first is the refetch handshake: a new cache error can coincide with the acknowledge of the pending request, and then it must reload rather than be lost or dropped. The second is the sticky flag: a software-read error can coincide with a clear or invalidate of that flag. The bench sweeps every combination of all four severities, the software-read flag, the handler mode, both enables, the acknowledge and the two clear inputs, against a cycle model in the bench, so both collisions occur many times under every enable setting. Each cycle is judged on the whole bus, the valid strobe, the exception and correction pulses, the refetch request and index, and the sticky flag.

// File: rtl/ecc_fault_pkg.sv
package ecc_fault_pkg;
  localparam int EVT_W = 30;

  typedef enum logic [1:0] {
    SEV_NONE   = 2'd0,
    SEV_SINGLE = 2'd1,
    SEV_DOUBLE = 2'd2,
    SEV_MULTI  = 2'd3
  } sev_e;

  localparam int B_EEH    = 0;
  localparam int B_RF_RE  = 1;
  localparam int B_RF_UE  = 2;
  localparam int B_TAG_RE = 3;
  localparam int B_DAT_RE = 4;
  localparam int B_TLB_RE = 19;
  localparam int B_TLB_UE = 20;
  localparam int B_TLB_SW = 21;

  localparam logic [EVT_W-1:0] EVT_USED_MASK =
    (EVT_W'(1) << B_EEH)    | (EVT_W'(1) << B_RF_RE)  | (EVT_W'(1) << B_RF_UE) |
    (EVT_W'(1) << B_TAG_RE) | (EVT_W'(1) << B_DAT_RE) | (EVT_W'(1) << B_TLB_RE) |
    (EVT_W'(1) << B_TLB_UE) | (EVT_W'(1) << B_TLB_SW);

  function automatic logic is_err(input logic [1:0] sev);
    return sev != SEV_NONE;
  endfunction

  function automatic logic is_single(input logic [1:0] sev);
    return sev == SEV_SINGLE;
  endfunction

  function automatic logic is_multi(input logic [1:0] sev);
    return sev[1];
  endfunction
endpackage

// File: rtl/ecc_event_reg.sv
module ecc_event_reg #(
  parameter int W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_d_i,
  output logic [W-1:0] evt_q_o,
  output logic         vld_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q_o <= '0;
      vld_q_o <= 1'b0;
    end else begin
      evt_q_o <= evt_d_i;
      vld_q_o <= |evt_d_i;
    end
  end
endmodule

// File: rtl/ecc_refetch_ctl.sv
module ecc_refetch_ctl #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  logic still_busy;
  assign still_busy = req_o & ~ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      idx_o <= '0;
    end else if (!still_busy) begin
      req_o <= err_i;
      if (err_i) idx_o <= idx_i;
    end
  end
endmodule

// File: rtl/ecc_ee_flag.sv
module ecc_ee_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/ecc_fault_router.sv
module ecc_fault_router
  import ecc_fault_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ecc_en_i,
  input  logic             ecc_exc_en_i,
  input  logic             handler_mode_i,
  input  logic [1:0]       rf_sev_i,
  input  logic [1:0]       ic_tag_sev_i,
  input  logic [1:0]       ic_dat_sev_i,
  input  logic [IDX_W-1:0] ic_idx_i,
  input  logic [1:0]       tlb_sev_i,
  input  logic             tlb_sw_i,
  input  logic             tlb_ee_clr_i,
  input  logic             tlb_inval_i,
  input  logic             refetch_ack_i,
  output logic             rf_fix_o,
  output logic             exc_req_o,
  output logic             refetch_req_o,
  output logic [IDX_W-1:0] refetch_idx_o,
  output logic             tlb_ee_o,
  output logic [EVT_W-1:0] evt_data_o,
  output logic             evt_valid_o
);
  logic rf_re, rf_ue, tag_re, dat_re, tlb_re, tlb_ue, tlb_swe, exc_cond;
  logic [EVT_W-1:0] evt_d;

  assign rf_re    = is_single(rf_sev_i);
  assign rf_ue    = is_multi(rf_sev_i);
  assign tag_re   = is_err(ic_tag_sev_i);
  assign dat_re   = is_err(ic_dat_sev_i);
  assign tlb_re   = ~tlb_sw_i & is_single(tlb_sev_i);
  assign tlb_ue   = ~tlb_sw_i & is_multi(tlb_sev_i);
  assign tlb_swe  =  tlb_sw_i & is_err(tlb_sev_i);
  assign exc_cond = rf_ue | tlb_ue;

  always_comb begin
    evt_d           = '0;
    evt_d[B_EEH]    = exc_cond & handler_mode_i;
    evt_d[B_RF_RE]  = rf_re;
    evt_d[B_RF_UE]  = rf_ue;
    evt_d[B_TAG_RE] = tag_re;
    evt_d[B_DAT_RE] = dat_re;
    evt_d[B_TLB_RE] = tlb_re;
    evt_d[B_TLB_UE] = tlb_ue;
    evt_d[B_TLB_SW] = tlb_swe;
  end

  ecc_event_reg #(.W(EVT_W)) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_d_i (evt_d),
    .evt_q_o (evt_data_o),
    .vld_q_o (evt_valid_o)
  );

  ecc_refetch_ctl #(.IDX_W(IDX_W)) u_refetch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_i  (tag_re | dat_re),
    .idx_i  (ic_idx_i),
    .ack_i  (refetch_ack_i),
    .req_o  (refetch_req_o),
    .idx_o  (refetch_idx_o)
  );

  ecc_ee_flag u_ee (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tlb_swe),
    .clr_i  (tlb_ee_clr_i | tlb_inval_i),
    .flag_o (tlb_ee_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_fix_o  <= 1'b0;
      exc_req_o <= 1'b0;
    end else begin
      rf_fix_o  <= rf_re;
      exc_req_o <= exc_cond & ecc_en_i & ecc_exc_en_i;
    end
  end
endmodule

// File: rtl/ecc_fault_router_chk.sv
module ecc_fault_router_chk
  import ecc_fault_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ecc_en_i,
  input logic             ecc_exc_en_i,
  input logic             tlb_ee_clr_i,
  input logic             tlb_inval_i,
  input logic             refetch_ack_i,
  input logic             rf_fix_o,
  input logic             exc_req_o,
  input logic             refetch_req_o,
  input logic [IDX_W-1:0] refetch_idx_o,
  input logic             tlb_ee_o,
  input logic [EVT_W-1:0] evt_data_o,
  input logic             evt_valid_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_data_o & ~EVT_USED_MASK) == '0); // R1
  AST_FIX_HAS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_fix_o |-> evt_data_o[B_RF_RE]); // R2
  AST_REFETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refetch_req_o && !refetch_ack_i |=> refetch_req_o && $stable(refetch_idx_o)); // R5
  AST_EE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_ee_o && !tlb_ee_clr_i && !tlb_inval_i |=> tlb_ee_o); // R8
  AST_EXC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> evt_data_o[B_RF_UE] || evt_data_o[B_TLB_UE]); // R9
  AST_EXC_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_req_o) |-> $past(ecc_en_i && ecc_exc_en_i)); // R9
  AST_EEH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_data_o[B_EEH] |-> evt_data_o[B_RF_UE] || evt_data_o[B_TLB_UE]); // R11
  AST_VALID_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o == (evt_data_o != '0)); // R12
endmodule

bind ecc_fault_router ecc_fault_router_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ecc_en_i      (ecc_en_i),
  .ecc_exc_en_i  (ecc_exc_en_i),
  .tlb_ee_clr_i  (tlb_ee_clr_i),
  .tlb_inval_i   (tlb_inval_i),
  .refetch_ack_i (refetch_ack_i),
  .rf_fix_o      (rf_fix_o),
  .exc_req_o     (exc_req_o),
  .refetch_req_o (refetch_req_o),
  .refetch_idx_o (refetch_idx_o),
  .tlb_ee_o      (tlb_ee_o),
  .evt_data_o    (evt_data_o),
  .evt_valid_o   (evt_valid_o)
);

// File: tb/tb_ecc_fault_router.sv
module tb_ecc_fault_router;
  localparam int IDX_W = 6;
  localparam int EW = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ecc_en, exc_en, hm, tsw, clr, inv, ack;
  logic [1:0] rf_sev, tag_sev, dat_sev, tlb_sev;
  logic [IDX_W-1:0] idx;
  logic rf_fix, exc_req, rq, ee, vld;
  logic [IDX_W-1:0] rq_idx;
  logic [EW-1:0] evt;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecc_fault_router #(.IDX_W(IDX_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ecc_en_i(ecc_en), .ecc_exc_en_i(exc_en),
    .handler_mode_i(hm), .rf_sev_i(rf_sev), .ic_tag_sev_i(tag_sev),
    .ic_dat_sev_i(dat_sev), .ic_idx_i(idx), .tlb_sev_i(tlb_sev), .tlb_sw_i(tsw),
    .tlb_ee_clr_i(clr), .tlb_inval_i(inv), .refetch_ack_i(ack),
    .rf_fix_o(rf_fix), .exc_req_o(exc_req), .refetch_req_o(rq),
    .refetch_idx_o(rq_idx), .tlb_ee_o(ee), .evt_data_o(evt), .evt_valid_o(vld)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model state
  logic m_rq, m_ee;
  logic [IDX_W-1:0] m_idx;

  initial begin
    ecc_en = 0; exc_en = 0; hm = 0; tsw = 0; clr = 0; inv = 0; ack = 0;
    rf_sev = 0; tag_sev = 0; dat_sev = 0; tlb_sev = 0; idx = 0;
    m_rq = 0; m_ee = 0; m_idx = 0;
    repeat (3) @(negedge clk);
    // reset state: all outputs low
    chk("R1 reset evt", 64'(evt), 0);
    chk("R12 reset valid", 64'(vld), 0);
    chk("R5 reset req", 64'(rq), 0);
    chk("R8 reset ee", 64'(ee), 0);
    chk("R9 reset exc", 64'(exc_req), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 32768; v++) begin
      logic [EW-1:0] e_evt;
      logic e_exc, e_fix, cond, icerr, busy;
      ack = v[0]; clr = v[1]; inv = v[2];
      tag_sev = v[4:3]; dat_sev = v[6:5]; tsw = v[7];
      tlb_sev = v[9:8]; rf_sev = v[11:10]; hm = v[12];
      exc_en = v[13]; ecc_en = v[14];
      idx = IDX_W'(v[5:0] ^ v[13:8]);
      // expected from the requirements
      e_evt = '0;
      e_evt[1]  = (rf_sev == 2'd1);                 // R2
      e_evt[2]  = (rf_sev >= 2'd2);                 // R3
      e_evt[3]  = (tag_sev != 0);                   // R4
      e_evt[4]  = (dat_sev != 0);                   // R4
      e_evt[19] = !tsw && (tlb_sev == 2'd1);        // R6
      e_evt[20] = !tsw && (tlb_sev >= 2'd2);        // R6
      e_evt[21] = tsw && (tlb_sev != 0);            // R7
      cond = e_evt[2] | e_evt[20];
      e_evt[0] = cond & hm;                         // R11
      e_exc = cond & ecc_en & exc_en;               // R9, bus independent of enables: R10
      e_fix = e_evt[1];
      icerr = e_evt[3] | e_evt[4];
      busy = m_rq & ~ack;
      if (!busy) begin
        m_rq = icerr;
        if (icerr) m_idx = idx;
      end
      if (e_evt[21]) m_ee = 1'b1;
      else if (clr | inv) m_ee = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R1/R3/R4/R6/R7/R10/R11 bus", 64'(evt), 64'(e_evt));
      chk("R12 valid", 64'(vld), 64'(e_evt != 0));
      chk("R9 exc", 64'(exc_req), 64'(e_exc));
      chk("R2 fix", 64'(rf_fix), 64'(e_fix));
      chk("R5 req", 64'(rq), 64'(m_rq));
      if (m_rq) chk("R5 idx", 64'(rq_idx), 64'(m_idx));
      chk("R8 ee", 64'(ee), 64'(m_ee));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule